// File: doc/BRIEF.md
# Integer ALU with Set-Less-Than

A purely combinational integer arithmetic and logic unit for an execution stage. Two operands of `WIDTH` bits (32 by default) and a 4-bit operation code enter. The unit returns a result word and three flags: carry, overflow and zero. It performs signed and unsigned addition and subtraction, four bitwise operations, and signed and unsigned magnitude compares.

One adder serves every arithmetic operation. For subtraction and for both compares, the unit inverts the second operand and forces a carry of one into the low end of the chain. A compare writes its answer into bit 0 of the result and clears every other bit. The overflow flag is only reported. It raises no trap, and the instruction decoder decides what an overflow means.

Top module: `int_alu`

## Requirements
- R1: With op_sel 0000 (signed add) or 0001 (unsigned add), result is a_in + b_in modulo 2^WIDTH, and carry_out is the carry out of the top bit.
- R2: overflow is 1 under op_sel 0000 or 0010 (signed subtract) exactly when the carry into the top bit differs from the carry out of it. This is the same as the true signed result lying outside the WIDTH-bit range.
- R3: With op_sel 0010 or 0011 (unsigned subtract), result is a_in - b_in modulo 2^WIDTH. carry_out is 1 when no borrow occurs, that is when a_in >= b_in taken as unsigned.
- R4: op_sel 0100 gives a_in AND b_in, 0101 gives OR, 0110 gives XOR, and 0111 gives NOR, the bitwise inverse of a_in OR b_in.
- R5: op_sel 1010 (signed compare) gives result bit 0 = 1 when a_in < b_in as two's complement numbers, including when a_in - b_in overflows. All higher result bits are 0.
- R6: op_sel 1011 (unsigned compare) gives result bit 0 = 1 when a_in < b_in as unsigned numbers. All higher result bits are 0.
- R7: overflow is 0 for every op_sel other than 0000 and 0010.
- R8: carry_out is 0 for the four bitwise codes. For both compare codes it is the carry out of the subtraction, as in R3.
- R9: zero is 1 exactly when every result bit is 0.
- R10: The unassigned codes 1000, 1001 and 1100 to 1111 give result 0, carry_out 0, overflow 0 and zero 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_in | input | WIDTH | First operand |
| b_in | input | WIDTH | Second operand, subtracted from a_in for subtract and compare codes |
| op_sel | input | 4 | Operation code |
| result | output | WIDTH | Operation result |
| carry_out | output | 1 | Adder carry out (no-borrow for subtract and compare) |
| overflow | output | 1 | Signed overflow for signed add and subtract |
| zero | output | 1 | All result bits are zero |

## Verification
The bench builds two copies of the unit. One uses WIDTH = 32 and takes directed corner operands plus a long pseudo-random stream. The other uses WIDTH = 4, which is small enough to sweep every operand pair under all sixteen operation codes. That sweep reaches every overflow and borrow pattern, the compares whose subtraction overflows, and every unassigned code. The 32-bit copy confirms that the same carry chain holds its behaviour at full width, at the most negative and most positive values.

// File: rtl/int_alu.sv
module int_alu #(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] a_in,
  input  logic [WIDTH-1:0] b_in,
  input  logic [3:0]       op_sel,
  output logic [WIDTH-1:0] result,
  output logic             carry_out,
  output logic             overflow,
  output logic             zero
);

  localparam logic [3:0] OP_ADD  = 4'b0000;
  localparam logic [3:0] OP_ADDU = 4'b0001;
  localparam logic [3:0] OP_SUB  = 4'b0010;
  localparam logic [3:0] OP_SUBU = 4'b0011;
  localparam logic [3:0] OP_AND  = 4'b0100;
  localparam logic [3:0] OP_OR   = 4'b0101;
  localparam logic [3:0] OP_XOR  = 4'b0110;
  localparam logic [3:0] OP_NOR  = 4'b0111;
  localparam logic [3:0] OP_SLT  = 4'b1010;
  localparam logic [3:0] OP_SLTU = 4'b1011;
  localparam int         MSB     = WIDTH - 1;

  logic             do_sub;
  logic [WIDTH-1:0] b_eff;
  logic [WIDTH-1:0] sum;
  logic [WIDTH:0]   cy;
  logic             ovf_raw;
  logic             lt_signed;
  logic             lt_unsigned;

  assign do_sub = (op_sel == OP_SUB) || (op_sel == OP_SUBU) ||
                  (op_sel == OP_SLT) || (op_sel == OP_SLTU);
  assign b_eff  = b_in ^ {WIDTH{do_sub}};
  assign cy[0]  = do_sub;

  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    assign sum[i]  = a_in[i] ^ b_eff[i] ^ cy[i];
    assign cy[i+1] = (a_in[i] & b_eff[i]) | (cy[i] & (a_in[i] ^ b_eff[i]));
  end

  assign ovf_raw     = cy[WIDTH] ^ cy[MSB];
  assign lt_signed   = sum[MSB] ^ ovf_raw;
  assign lt_unsigned = ~cy[WIDTH];

  always_comb begin
    result    = '0;
    carry_out = 1'b0;
    overflow  = 1'b0;
    unique case (op_sel)
      OP_ADD, OP_SUB: begin
        result    = sum;
        carry_out = cy[WIDTH];
        overflow  = ovf_raw;
      end
      OP_ADDU, OP_SUBU: begin
        result    = sum;
        carry_out = cy[WIDTH];
      end
      OP_AND: result = a_in & b_in;
      OP_OR:  result = a_in | b_in;
      OP_XOR: result = a_in ^ b_in;
      OP_NOR: result = ~(a_in | b_in);
      OP_SLT: begin
        result[0] = lt_signed;
        carry_out = cy[WIDTH];
      end
      OP_SLTU: begin
        result[0] = lt_unsigned;
        carry_out = cy[WIDTH];
      end
      default: ;
    endcase
  end

  assign zero = ~|result;

  always_comb begin
    if (op_sel == OP_ADD || op_sel == OP_ADDU)
      AST_ADD_SUM: assert ({carry_out, result} == ({1'b0, a_in} + {1'b0, b_in})); // R1
    if (op_sel == OP_SUB || op_sel == OP_SUBU)
      AST_SUB_DIFF: assert (result == WIDTH'(a_in - b_in)); // R3
    if (op_sel == OP_ADD && overflow)
      AST_ADD_OVF_SIGNS: assert (a_in[MSB] == b_in[MSB] && result[MSB] != a_in[MSB]); // R2
    if (op_sel == OP_SLT || op_sel == OP_SLTU)
      AST_CMP_UPPER_CLEAR: assert (result[MSB:1] == '0 || WIDTH == 1); // R5
    if (overflow)
      AST_OVF_SIGNED_ONLY: assert (op_sel == OP_ADD || op_sel == OP_SUB); // R7
    if (op_sel[3:2] == 2'b01)
      AST_LOGIC_NO_CARRY: assert (!carry_out); // R8
    if (op_sel[3] && op_sel[2:1] != 2'b01)
      AST_UNUSED_CLEAR: assert (zero && !carry_out && !overflow); // R10
  end

endmodule

// File: tb/sim_int_alu.sv
module sim_int_alu;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 50000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  int   n_checks = 0;
  int   n_fail = 0;
  int   cycles = 0;
  bit   done = 0;

  logic [31:0] a32 = '0, b32 = '0, r32;
  logic [3:0]  m32 = '0;
  logic        c32, o32, z32;
  logic [3:0]  a4 = '0, b4 = '0, r4;
  logic [3:0]  m4 = '0;
  logic        c4, o4, z4;

  always #(CLK_PERIOD/2) clk = ~clk;

  int_alu #(.WIDTH(32)) u0 (.a_in(a32), .b_in(b32), .op_sel(m32),
    .result(r32), .carry_out(c32), .overflow(o32), .zero(z32));
  int_alu #(.WIDTH(4)) u1 (.a_in(a4), .b_in(b4), .op_sel(m4),
    .result(r4), .carry_out(c4), .overflow(o4), .zero(z4));

  function automatic string req_of(input logic [3:0] m);
    case (m)
      4'b0000, 4'b0001: return "R1";
      4'b0010, 4'b0011: return "R3";
      4'b0100, 4'b0101, 4'b0110, 4'b0111: return "R4";
      4'b1010: return "R5";
      4'b1011: return "R6";
      default: return "R10";
    endcase
  endfunction

  task automatic model(input int w, input logic [31:0] a, input logic [31:0] b,
                       input logic [3:0] m, output logic [31:0] r,
                       output logic c, output logic o, output logic z);
    logic [63:0] mask, ua, ub, t;
    longint sa, sb, st, lo, hi;
    mask = (64'd1 << w) - 1;
    ua = {32'd0, a} & mask;
    ub = {32'd0, b} & mask;
    sa = longint'(ua); if (ua[w-1]) sa -= longint'(64'd1 << w);
    sb = longint'(ub); if (ub[w-1]) sb -= longint'(64'd1 << w);
    hi = longint'((64'd1 << (w-1)) - 1);
    lo = -hi - 1;
    t = 0; c = 0; o = 0;
    case (m)
      4'b0000, 4'b0001: begin
        t = ua + ub; c = t[w];
        st = sa + sb; if (m == 4'b0000) o = (st > hi) || (st < lo);
      end
      4'b0010, 4'b0011: begin
        t = ua + (~ub & mask) + 1; c = (ua >= ub);
        st = sa - sb; if (m == 4'b0010) o = (st > hi) || (st < lo);
      end
      4'b0100: t = ua & ub;
      4'b0101: t = ua | ub;
      4'b0110: t = ua ^ ub;
      4'b0111: t = ~(ua | ub);
      4'b1010: begin t = {63'd0, sa < sb}; c = (ua >= ub); end
      4'b1011: begin t = {63'd0, ua < ub}; c = (ua >= ub); end
      default: t = 0;
    endcase
    r = 32'(t & mask);
    z = (r == 0);
  endtask

  task automatic compare(input string tag, input logic [31:0] ar, input logic ac,
                         input logic ao, input logic az, input logic [31:0] er,
                         input logic ec, input logic eo, input logic ez);
    n_checks++;
    if (ar !== er || ac !== ec || ao !== eo || az !== ez) begin
      n_fail++;
      $display("FAIL %s: got r=%h c=%b o=%b z=%b, expected r=%h c=%b o=%b z=%b",
               tag, ar, ac, ao, az, er, ec, eo, ez);
    end
  endtask

  task automatic apply32(input logic [31:0] a, input logic [31:0] b, input logic [3:0] m);
    logic [31:0] er; logic ec, eo, ez;
    @(posedge clk);
    a32 = a; b32 = b; m32 = m;
    @(negedge clk);
    model(32, a, b, m, er, ec, eo, ez);
    compare(req_of(m), r32, c32, o32, z32, er, ec, eo, ez);
  endtask

  task automatic test_reset_state();
    @(negedge clk);
    compare("R9 reset", r32, c32, o32, z32, 32'd0, 1'b0, 1'b0, 1'b1);
  endtask

  task automatic test_add_corners();
    apply32(32'hFFFF_FFFF, 32'd1, 4'b0000);   // R1 wrap, carry, R9 zero
    apply32(32'h7FFF_FFFF, 32'd1, 4'b0000);   // R2 positive overflow
    apply32(32'h8000_0000, 32'h8000_0000, 4'b0000); // R2 negative overflow
    apply32(32'h7FFF_FFFF, 32'd1, 4'b0001);   // R7 unsigned add no overflow
    apply32(32'h1234_5678, 32'h0FED_CBA9, 4'b0001);
  endtask

  task automatic test_sub_corners();
    apply32(32'h8000_0000, 32'd1, 4'b0010);   // R2 subtract overflow
    apply32(32'h7FFF_FFFF, 32'hFFFF_FFFF, 4'b0010);
    apply32(32'd5, 32'd5, 4'b0010);           // R3 no borrow, R9 zero
    apply32(32'd3, 32'd5, 4'b0011);           // R3 borrow, carry 0
    apply32(32'h8000_0000, 32'd1, 4'b0011);   // R7 no overflow for unsigned
  endtask

  task automatic test_logic_ops();
    apply32(32'hF0F0_1234, 32'h0FF0_4321, 4'b0100); // R4
    apply32(32'hF0F0_1234, 32'h0FF0_4321, 4'b0101);
    apply32(32'hF0F0_1234, 32'h0FF0_4321, 4'b0110);
    apply32(32'd0, 32'd0, 4'b0111);                 // R4 NOR all ones
    apply32(32'hFFFF_FFFF, 32'd0, 4'b0111);         // R9 NOR to zero, R8 carry 0
  endtask

  task automatic test_compares();
    apply32(32'h8000_0000, 32'd1, 4'b1010);         // R5 overflowing difference
    apply32(32'h7FFF_FFFF, 32'hFFFF_FFFF, 4'b1010); // R5 overflow, not less
    apply32(32'hFFFF_FFFF, 32'd0, 4'b1010);         // R5 -1 < 0
    apply32(32'd7, 32'd7, 4'b1010);                 // R5 equal
    apply32(32'd0, 32'hFFFF_FFFF, 4'b1011);         // R6 unsigned less
    apply32(32'hFFFF_FFFF, 32'd0, 4'b1011);         // R6 not less, R8 carry
  endtask

  task automatic test_unused_codes();
    apply32(32'hDEAD_BEEF, 32'h1234_5678, 4'b1000); // R10
    apply32(32'hDEAD_BEEF, 32'h1234_5678, 4'b1001);
    apply32(32'hFFFF_FFFF, 32'hFFFF_FFFF, 4'b1111);
  endtask

  task automatic test_random32(input int count);
    logic [3:0] codes [10] = '{4'b0000, 4'b0001, 4'b0010, 4'b0011, 4'b0100,
                               4'b0101, 4'b0110, 4'b0111, 4'b1010, 4'b1011};
    for (int k = 0; k < count; k++) begin
      logic [31:0] a, b;
      a = $urandom; b = $urandom;
      if (k % 7 == 0) b = a;
      if (k % 11 == 0) a[31] = ~b[31];
      apply32(a, b, codes[k % 10]);
    end
  endtask

  task automatic test_sweep4();
    for (int m = 0; m < 16; m++) begin
      for (int a = 0; a < 16; a++) begin
        for (int b = 0; b < 16; b++) begin
          logic [31:0] er; logic ec, eo, ez;
          @(posedge clk);
          a4 = 4'(a); b4 = 4'(b); m4 = 4'(m);
          @(negedge clk);
          model(4, 32'(a), 32'(b), 4'(m), er, ec, eo, ez);
          compare({req_of(4'(m)), " w4"}, {28'd0, r4}, c4, o4, z4, er, ec, eo, ez);
        end
      end
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > WATCHDOG) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: got %0d cycles, expected at most %0d", cycles, WATCHDOG);
      finish_run();
    end
  end

  initial begin
    test_reset_state();
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    test_add_corners();
    test_sub_corners();
    test_logic_ops();
    test_compares();
    test_unused_codes();
    test_random32(2000);
    test_sweep4();
    finish_run();
  end
endmodule